// File: doc/BRIEF.md
# Flash protection lock unit

This block keeps per-chunk write and copy protection for a 2 MB flash and
decides, for every flash access, whether the access must be refused. Each
protection bit guards one 16 KB chunk. Four write-protect words and four
read-protect words of 32 bits each cover the flash, one word per 512 KB. A
bit reading 1 leaves its chunk open. A bit reading 0 protects it. Software
clears a bit by writing 1 to it. Nothing but a reset sets it back to 1, so at
run time protection can only be added.

A lock register holds three write-one-to-clear control bits, all 1 after
reset. They are a boot-visible flag, a secure-boot lock and the protection
lock. The protection lock is a two-state machine. In `LK_OPEN` (lock bit 1)
mask writes are accepted. A register write to the lock word with bit 2 set
takes the transition `LK_OPEN -> LK_SEALED`. In `LK_SEALED` (lock bit 0) the
machine loops on itself until reset, and every mask write is dropped without
any error. Reset is the only way back from `LK_SEALED` to `LK_OPEN`.

The access-check port takes a flash byte address and an access type. It
returns a combinational deny when a write targets a chunk whose write bit is 0,
or when a read targets a chunk whose read bit is 0.

Top module: `flash_prot_lock`

## Requirements
- R1: After reset every bit of all eight protection words reads 1 and the lock register reads 0x7.
- R2: A register write to a protection word clears each mask bit whose write-data bit is 1, provided the protection lock is 1. Mask bits whose write-data bit is 0 keep their value.
- R3: A protection bit that is 0 stays 0 under any register write until the next reset, so writing 0 or 1 never returns it to 1.
- R4: Lock register bit 0 (boot-visible), bit 1 (secure-boot lock) and bit 2 (protection lock) are write-one-to-clear. Writing 0 to a lock bit leaves it unchanged, and once cleared a lock bit stays 0 until reset.
- R5: While the protection lock is 0, writes to any protection word are ignored and the masks keep their values.
- R6: The chunk of an access is address bits [20:14]. Bits [20:19] pick the 32-bit word (0 to 3) and bits [18:14] pick the bit in that word. Bits [13:0] do not matter.
- R7: With acc_is_write=1 the deny output equals the inverse of the selected write-protect bit. With acc_is_write=0 it equals the inverse of the selected read-protect bit.
- R8: The register bus uses word indices. Index 0 is the lock register, with data in bits [2:0] and 0 in the upper bits. Indices 4 to 7 are write-protect words 0 to 3. Indices 8 to 11 are read-protect words 0 to 3. Any other index reads 0, and writes to it change nothing.
- R9: reg_rdata and acc_deny are combinational in their inputs. A register write is committed at the clock edge where reg_we is 1, and it shows on both outputs right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 4 | Register word index |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| acc_addr | input | 21 | Flash byte address under check |
| acc_is_write | input | 1 | 1 = write access, 0 = read access |
| acc_deny | output | 1 | Access refused |

## Verification
Register writes take effect at the single rising edge where reg_we is 1. The read data and the deny output are pure logic on top of the stored masks, so each result is due in the cycle right after that edge, with no extra register delay. The bench drives every input on a falling edge, drops the write strobe on the next falling edge, and samples reg_rdata and acc_deny one time unit after a later falling edge. By then the write has been committed and the combinational outputs have settled on the new input values.

// File: rtl/flp_pkg.sv
package flp_pkg;

    // Protection-lock state: open allows mask updates, sealed freezes them.
    typedef enum logic [0:0] {
        LK_OPEN   = 1'b0,
        LK_SEALED = 1'b1
    } lock_state_e;

    // Bit positions inside the lock register.
    localparam int LB_BOOTVIS = 0;
    localparam int LB_SBOOT   = 1;
    localparam int LB_PROT    = 2;
    localparam int LOCK_BITS  = 3;

    // Register word indices.
    localparam int IDX_LOCK    = 0;
    localparam int IDX_WP_BASE = 4;
    localparam int IDX_RP_BASE = 8;

endpackage

// File: rtl/flp_lock_ctrl.sv
module flp_lock_ctrl
    import flp_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 lock_we,
    input  logic [LOCK_BITS-1:0] lock_wdata,
    output logic [LOCK_BITS-1:0] lock_bits,
    output logic                 prot_allow
);

    lock_state_e state_q, state_d;
    logic        bootvis_q;
    logic        sboot_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LK_OPEN;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: open -> sealed on a one written to the protection lock bit
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LK_OPEN: begin
                if (lock_we && lock_wdata[LB_PROT]) begin
                    state_d = LK_SEALED;
                end
            end
            LK_SEALED: begin
                state_d = LK_SEALED;
            end
        endcase
    end

    // Outputs of the state machine
    always_comb begin
        unique case (state_q)
            LK_OPEN:   prot_allow = 1'b1;
            LK_SEALED: prot_allow = 1'b0;
        endcase
    end

    // The two other control bits: plain write-one-to-clear flops
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bootvis_q <= 1'b1;
            sboot_q   <= 1'b1;
        end else if (lock_we) begin
            if (lock_wdata[LB_BOOTVIS]) bootvis_q <= 1'b0;
            if (lock_wdata[LB_SBOOT])   sboot_q   <= 1'b0;
        end
    end

    always_comb begin
        lock_bits              = '0;
        lock_bits[LB_BOOTVIS]  = bootvis_q;
        lock_bits[LB_SBOOT]    = sboot_q;
        lock_bits[LB_PROT]     = prot_allow;
    end

endmodule

// File: rtl/flp_mask_bank.sv
module flp_mask_bank #(
    parameter int NUM_WORDS = 4,
    parameter int WORD_W    = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_WORDS-1:0]          word_sel,
    input  logic                          allow,
    input  logic [WORD_W-1:0]             wdata,
    output logic [NUM_WORDS*WORD_W-1:0]   masks
);

    localparam int TOTAL_W = NUM_WORDS * WORD_W;

    logic [TOTAL_W-1:0] mask_q;

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mask_q[w*WORD_W +: WORD_W] <= '1;
            end else if (word_sel[w] && allow) begin
                // Ones in the write data clear bits; nothing sets them.
                mask_q[w*WORD_W +: WORD_W] <= mask_q[w*WORD_W +: WORD_W] & ~wdata;
            end
        end
    end

    assign masks = mask_q;

endmodule

// File: rtl/flp_access_check.sv
module flp_access_check #(
    parameter int ACC_AW    = 21,
    parameter int CHUNK_LSB = 14,
    parameter int NUM_WORDS = 4,
    parameter int WORD_W    = 32
) (
    input  logic [ACC_AW-1:0]           acc_addr,
    input  logic                        acc_is_write,
    input  logic [NUM_WORDS*WORD_W-1:0] wp_masks,
    input  logic [NUM_WORDS*WORD_W-1:0] rp_masks,
    output logic                        deny
);

    localparam int IDX_W = ACC_AW - CHUNK_LSB;

    logic [IDX_W-1:0]     chunk;
    logic [CHUNK_LSB-1:0] unused_offset;
    logic                 wp_open;
    logic                 rp_open;

    // Word select is the top of the chunk index, bit select the rest,
    // so the chunk index is directly the flat bit position.
    assign chunk         = acc_addr[CHUNK_LSB +: IDX_W];
    assign unused_offset = acc_addr[CHUNK_LSB-1:0];
    assign wp_open       = wp_masks[chunk];
    assign rp_open       = rp_masks[chunk];
    assign deny          = acc_is_write ? !wp_open : !rp_open;

endmodule

// File: rtl/flash_prot_lock.sv
module flash_prot_lock
    import flp_pkg::*;
#(
    parameter int REG_AW    = 4,
    parameter int WORD_W    = 32,
    parameter int NUM_WORDS = 4,
    parameter int ACC_AW    = 21,
    parameter int CHUNK_LSB = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic              reg_we,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    input  logic [ACC_AW-1:0] acc_addr,
    input  logic              acc_is_write,
    output logic              acc_deny
);

    localparam int TOTAL_W = NUM_WORDS * WORD_W;

    logic [NUM_WORDS-1:0] wp_sel;
    logic [NUM_WORDS-1:0] rp_sel;
    logic                 lock_we;
    logic [LOCK_BITS-1:0] lock_bits;
    logic                 prot_allow;
    logic [TOTAL_W-1:0]   wp_masks;
    logic [TOTAL_W-1:0]   rp_masks;

    // Write decode
    assign lock_we = reg_we && (reg_addr == REG_AW'(IDX_LOCK));

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_dec
        assign wp_sel[w] = reg_we && (reg_addr == REG_AW'(IDX_WP_BASE + w));
        assign rp_sel[w] = reg_we && (reg_addr == REG_AW'(IDX_RP_BASE + w));
    end

    flp_lock_ctrl u_lock (
        .clk        (clk),
        .rst_n      (rst_n),
        .lock_we    (lock_we),
        .lock_wdata (reg_wdata[LOCK_BITS-1:0]),
        .lock_bits  (lock_bits),
        .prot_allow (prot_allow)
    );

    flp_mask_bank #(.NUM_WORDS(NUM_WORDS), .WORD_W(WORD_W)) u_wp (
        .clk      (clk),
        .rst_n    (rst_n),
        .word_sel (wp_sel),
        .allow    (prot_allow),
        .wdata    (reg_wdata),
        .masks    (wp_masks)
    );

    flp_mask_bank #(.NUM_WORDS(NUM_WORDS), .WORD_W(WORD_W)) u_rp (
        .clk      (clk),
        .rst_n    (rst_n),
        .word_sel (rp_sel),
        .allow    (prot_allow),
        .wdata    (reg_wdata),
        .masks    (rp_masks)
    );

    flp_access_check #(
        .ACC_AW    (ACC_AW),
        .CHUNK_LSB (CHUNK_LSB),
        .NUM_WORDS (NUM_WORDS),
        .WORD_W    (WORD_W)
    ) u_chk_acc (
        .acc_addr     (acc_addr),
        .acc_is_write (acc_is_write),
        .wp_masks     (wp_masks),
        .rp_masks     (rp_masks),
        .deny         (acc_deny)
    );

    // Read mux
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == REG_AW'(IDX_LOCK)) begin
            reg_rdata[LOCK_BITS-1:0] = lock_bits;
        end
        for (int w = 0; w < NUM_WORDS; w++) begin
            if (reg_addr == REG_AW'(IDX_WP_BASE + w)) reg_rdata = wp_masks[w*WORD_W +: WORD_W];
            if (reg_addr == REG_AW'(IDX_RP_BASE + w)) reg_rdata = rp_masks[w*WORD_W +: WORD_W];
        end
    end

endmodule

// File: rtl/flash_prot_lock_chk.sv
module flash_prot_lock_chk #(
    parameter int REG_AW    = 4,
    parameter int WORD_W    = 32,
    parameter int NUM_WORDS = 4
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        prot_allow,
    input logic [NUM_WORDS*WORD_W-1:0] wp_masks,
    input logic [NUM_WORDS*WORD_W-1:0] rp_masks,
    input logic                        acc_is_write,
    input logic                        acc_deny,
    input logic [REG_AW-1:0]           reg_addr,
    input logic [WORD_W-1:0]           reg_rdata
);

    localparam int RP_END = flp_pkg::IDX_RP_BASE + NUM_WORDS;

    // R3: no protection bit ever returns from 0 to 1 outside reset
    p_sticky_wp_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wp_masks & ~$past(wp_masks)) == '0);
    p_sticky_rp_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rp_masks & ~$past(rp_masks)) == '0);

    // R5: once sealed, the masks are frozen
    p_frozen_sealed_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !prot_allow |=> ($stable(wp_masks) && $stable(rp_masks)));

    // R4: the protection lock never reopens without reset
    p_lock_stays_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !prot_allow |=> !prot_allow);

    // R7: fully open write masks never deny a write; fully closed read masks deny every read
    p_open_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_is_write && (&wp_masks)) |-> !acc_deny);
    p_closed_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_is_write && (rp_masks == '0)) |-> acc_deny);

    // R8: unmapped indices read zero
    p_unmapped_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((int'(reg_addr) >= RP_END) ||
         (int'(reg_addr) > flp_pkg::IDX_LOCK && int'(reg_addr) < flp_pkg::IDX_WP_BASE))
        |-> (reg_rdata == '0));

endmodule

bind flash_prot_lock flash_prot_lock_chk #(
    .REG_AW    (REG_AW),
    .WORD_W    (WORD_W),
    .NUM_WORDS (NUM_WORDS)
) u_prot_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .prot_allow   (prot_allow),
    .wp_masks     (wp_masks),
    .rp_masks     (rp_masks),
    .acc_is_write (acc_is_write),
    .acc_deny     (acc_deny),
    .reg_addr     (reg_addr),
    .reg_rdata    (reg_rdata)
);

// File: tb/flash_prot_lock_bench.sv
module flash_prot_lock_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [20:0] acc_addr = '0;
    logic        acc_is_write = 1'b0;
    logic        acc_deny;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    logic [31:0] exp_wp [4];
    logic [31:0] exp_rp [4];
    logic [2:0]  exp_lock;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_prot_lock u_flash_prot_lock (
        .clk          (clk),
        .rst_n        (rst_n),
        .reg_addr     (reg_addr),
        .reg_we       (reg_we),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .acc_addr     (acc_addr),
        .acc_is_write (acc_is_write),
        .acc_deny     (acc_deny)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int w = 0; w < 4; w++) begin
            exp_wp[w] = '1;
            exp_rp[w] = '1;
        end
        exp_lock = 3'b111;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr  = a;
        reg_wdata = d;
        reg_we    = 1'b1;
        @(negedge clk);
        reg_we    = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [3:0] a, input logic [31:0] exp);
        @(negedge clk);
        reg_addr = a;
        #1;
        chk(req, $sformatf("read idx %0d", a), reg_rdata, exp);
    endtask

    task automatic acc_chk(input string req, input logic [20:0] a, input logic is_wr, input logic exp);
        @(negedge clk);
        acc_addr     = a;
        acc_is_write = is_wr;
        #1;
        chk(req, $sformatf("deny addr %h wr %0b", a, is_wr), {31'b0, acc_deny}, {31'b0, exp});
    endtask

    task automatic check_all_regs(input string req);
        rd_chk(req, 4'd0, {29'b0, exp_lock});
        for (int w = 0; w < 4; w++) begin
            rd_chk(req, 4'(4 + w), exp_wp[w]);
            rd_chk(req, 4'(8 + w), exp_rp[w]);
        end
    endtask

    // R1: reset values
    task automatic t_reset();
        check_all_regs("R1");
        acc_chk("R1", 21'h000000, 1'b1, 1'b0);
        acc_chk("R1", 21'h1FFFFF, 1'b0, 1'b0);
    endtask

    // R2, R6, R7, R9: clear one write-protect bit and probe its chunk
    task automatic t_clear_write();
        wr(4'd5, 32'h0000_0008);
        exp_wp[1] = exp_wp[1] & ~32'h0000_0008;
        rd_chk("R2", 4'd5, 32'hFFFF_FFF7);
        acc_chk("R7", 21'h08C000, 1'b1, 1'b1);
        acc_chk("R6", 21'h08FFFF, 1'b1, 1'b1);
        acc_chk("R6", 21'h088000, 1'b1, 1'b0);
        acc_chk("R7", 21'h08C000, 1'b0, 1'b0);
        acc_chk("R6", 21'h00C000, 1'b1, 1'b0);
    endtask

    // R2, R6, R7: clear the last read-protect bit of the top word
    task automatic t_clear_read();
        wr(4'd11, 32'h8000_0000);
        exp_rp[3] = exp_rp[3] & ~32'h8000_0000;
        rd_chk("R2", 4'd11, 32'h7FFF_FFFF);
        acc_chk("R7", 21'h1FC000, 1'b0, 1'b1);
        acc_chk("R6", 21'h1FFFFF, 1'b0, 1'b1);
        acc_chk("R7", 21'h1FC000, 1'b1, 1'b0);
        acc_chk("R6", 21'h1F8000, 1'b0, 1'b0);
    endtask

    // R3: zeros written leave masks alone; cleared bits never come back
    task automatic t_sticky();
        wr(4'd5, 32'h0000_0000);
        rd_chk("R3", 4'd5, exp_wp[1]);
        wr(4'd5, 32'h0000_0003);
        exp_wp[1] = exp_wp[1] & ~32'h0000_0003;
        rd_chk("R3", 4'd5, 32'hFFFF_FFF4);
        acc_chk("R3", 21'h08C000, 1'b1, 1'b1);
    endtask

    // R8: unmapped indices read zero and writes to them change nothing
    task automatic t_unmapped();
        wr(4'd2, 32'hFFFF_FFFF);
        wr(4'd13, 32'hFFFF_FFFF);
        rd_chk("R8", 4'd2, 32'h0);
        rd_chk("R8", 4'd12, 32'h0);
        rd_chk("R8", 4'd15, 32'h0);
        check_all_regs("R8");
    endtask

    // R4: lock bits are write-one-to-clear, zeros have no effect
    task automatic t_lock_bits();
        wr(4'd0, 32'h0000_0001);
        exp_lock = 3'b110;
        rd_chk("R4", 4'd0, 32'h6);
        wr(4'd0, 32'h0000_0000);
        rd_chk("R4", 4'd0, 32'h6);
        wr(4'd0, 32'h0000_0002);
        exp_lock = 3'b100;
        rd_chk("R4", 4'd0, 32'h4);
    endtask

    // R5, R4: sealed lock freezes masks and cannot reopen
    task automatic t_seal();
        wr(4'd0, 32'h0000_0004);
        exp_lock = 3'b000;
        rd_chk("R4", 4'd0, 32'h0);
        wr(4'd4, 32'hFFFF_FFFF);
        wr(4'd9, 32'h0000_00FF);
        check_all_regs("R5");
        acc_chk("R5", 21'h000000, 1'b1, 1'b0);
        acc_chk("R5", 21'h080000, 1'b0, 1'b0);
        wr(4'd0, 32'h0000_0007);
        rd_chk("R4", 4'd0, 32'h0);
    endtask

    // R1: a second reset restores everything
    task automatic t_rereset();
        do_reset();
        check_all_regs("R1");
        acc_chk("R1", 21'h08C000, 1'b1, 1'b0);
        acc_chk("R1", 21'h1FC000, 1'b0, 1'b0);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_clear_write();
        t_clear_read();
        t_sticky();
        t_unmapped();
        t_lock_bits();
        t_seal();
        t_rereset();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule